// File: doc/BRIEF.md
# Gated Time-Base Counter with Trigger Start

This block is the shared time base for a bank of capture/compare channels. It picks one of five count-enable sources: the bus clock itself, or one of four slower events divided by two. The chosen enable passes through a 10-bit programmable divider, and each divider tick advances a 16-bit up-counter. When the counter reaches a programmable upper limit, the next tick takes it back to zero. That wrap raises a one-cycle tick and a sticky overflow flag, and it reloads the limit from a shadow register.

Counting is controlled by a run bit. Optionally, a selected edge on one of four trigger inputs is also required, and once counting has started it carries on even after the trigger goes away. Counting is suspended by an enabled halt input, which also latches a flag that can raise an interrupt. It is also suspended while the core is idle or halted for debug, unless bypass bits let the counter carry on in those states.

Software reaches the block through a single-cycle write strobe with an address and write data, and through a combinational read-data port.

Top module: `tbase_counter`

Register map (by `reg_addr`):

| Address | Register | Fields |
|---|---|---|
| 0 | CFG | [9:0] divide ratio, [12:10] source, [13] trigger enable, [14] trigger rising, [16:15] trigger select, [17] halt enable, [18] halt interrupt enable, [19] idle run, [20] debug run, [21] update hold |
| 1 | STAT | [0] run, [1] overflow flag, [2] halt flag, [3] started, [4] divider half, [25:16] divider count |
| 2 | COUNT | counter value |
| 3 | LIMIT | upper limit |
| 4 | SHADOW | next limit |

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, `count_o` is 0, and `ovf_tick_o`, `ovf_flag_o` and `halt_irq_o` are low.
- R2: With source 0 (bus clock), the counter advances once every R running cycles, where R is CFG[9:0] and a value of 0 means 1024. The divider count reads back in STAT[25:16]. The half-cycle state reads back in STAT[4] and is 1 when the divider count is at least R/2. Writing COUNT also clears the divider and the divide-by-two stages.
- R3: When a tick arrives with the counter equal to LIMIT (address 3), the counter goes to 0 and `ovf_tick_o` pulses for one cycle, so wraps repeat every R*(LIMIT+1) cycles.
- R4: A wrap sets the overflow flag (STAT[1], `ovf_flag_o`). A STAT write with bit 1 = 0 clears it, and a STAT write with bit 1 = 1 leaves it unchanged.
- R5: On each wrap, LIMIT is loaded from SHADOW (address 4), unless the update-hold bit CFG[21] is 1, in which case LIMIT keeps its value.
- R6: With CFG[13] = 0 the counter runs while the run bit STAT[0] is 1. With CFG[13] = 1 and run set, counting starts only on the edge selected by CFG[14] (1 = rising, 0 = falling) of `trig_in[CFG[16:15]]`, and it continues after the trigger returns. STAT[3] shows the started state, and clearing run clears it.
- R7: With CFG[17] = 1, a high `halt_in` freezes the counter and sets the sticky halt flag STAT[2]. A STAT write with bit 2 = 0 clears the flag. `halt_irq_o` is the flag ANDed with CFG[18]. With CFG[17] = 0, `halt_in` has no effect.
- R8: A high `core_idle` freezes the counter unless CFG[19] = 1. A high `core_debug` freezes it unless CFG[20] = 1.
- R9: Sources 1 to 4 give one count enable for every second event: source 1 counts `tmr_ovf_in` high cycles, source 2 counts falling edges of `ext_in`, source 3 counts rising edges of `xosc_in`, and source 4 counts any transition of `ext_in`. The asynchronous inputs pass through a two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 22 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| tmr_ovf_in | input | 1 | Synchronous timer overflow event |
| ext_in | input | 1 | Asynchronous external count input |
| xosc_in | input | 1 | Asynchronous external oscillator |
| trig_in | input | 4 | Asynchronous start triggers |
| halt_in | input | 1 | Asynchronous halt request |
| core_idle | input | 1 | Core is idle |
| core_debug | input | 1 | Core is halted for debug |
| count_o | output | 16 | Counter value |
| ovf_tick_o | output | 1 | One-cycle wrap pulse |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| halt_irq_o | output | 1 | Halt interrupt |

## Verification
The wrap period is measured between consecutive wrap pulses for three settings:

- ratio 1 with limit 4;
- ratio 3 with limit 2;
- ratio 0 with limit 1.

These separate an off-by-one in the limit compare from one in the divider, and they exercise the 1024 encoding. Shadow reload and update hold are told apart by a change in period after the first wrap. Trigger start is tried with a wrong trigger line, with a wrong edge, and after the trigger returns. The same external waveform is fed to the falling-edge source and to the any-transition source, which must count 2 and 4 respectively.

// File: rtl/tbase_pkg.sv
// Shared types for the time-base counter.
// Assumes: a register bus with a one-cycle write strobe.
package tbase_pkg;
    localparam int DIV_W   = 10;
    localparam int SRC_W   = 3;
    localparam int N_TRIG  = 4;
    localparam int TSEL_W  = $clog2(N_TRIG);
    localparam int N_SRC   = 5;

    typedef struct packed {
        logic              upd_hold;
        logic              dbg_run;
        logic              idle_run;
        logic              halt_irq_en;
        logic              halt_en;
        logic [TSEL_W-1:0] trig_sel;
        logic              trig_rise;
        logic              trig_en;
        logic [SRC_W-1:0]  src_sel;
        logic [DIV_W-1:0]  ratio;
    } cfg_t;

    localparam int WD_W = $bits(cfg_t);

    typedef enum logic [2:0] {
        A_CFG    = 3'd0,
        A_STAT   = 3'd1,
        A_COUNT  = 3'd2,
        A_LIMIT  = 3'd3,
        A_SHADOW = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/tbase_sync.sv
// Two-flop synchronizer for a vector of asynchronous levels.
// Assumes: each bit is independent (no bus coherency is needed).
module tbase_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] lvl_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two flop stages to resolve metastability
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign lvl_o = sync_q;
endmodule

// File: rtl/tbase_clk_src.sv
// Count-enable source selection with divide-by-two stages.
// Assumes: tmr_ovf_in is synchronous; ext_in and xosc_in are asynchronous.
module tbase_clk_src
    import tbase_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] sel,
    input  logic             clr,
    input  logic             tmr_ovf_in,
    input  logic             ext_in,
    input  logic             xosc_in,
    output logic             src_en
);
    logic [1:0]       lvl;
    logic [1:0]       prev_q;
    logic [N_SRC-1:0] ev;
    logic [N_SRC-1:0] pre;

    tbase_sync #(.W(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({xosc_in, ext_in}),
        .lvl_o  (lvl)
    );

    // Delayed copy of the synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    assign ev[0] = 1'b1;
    assign ev[1] = tmr_ovf_in;
    assign ev[2] = prev_q[0] & ~lvl[0];
    assign ev[3] = lvl[1] & ~prev_q[1];
    assign ev[4] = lvl[0] ^ prev_q[0];

    assign pre[0] = (sel == SRC_W'(0));

    for (genvar i = 1; i < N_SRC; i++) begin : g_div2
        logic tog_q;
        // Toggle on every qualifying event of the selected source
        always_ff @(posedge clk) begin
            if (!rst_n)                           tog_q <= 1'b0;
            else if (clr)                         tog_q <= 1'b0;
            else if (sel == SRC_W'(i) && ev[i])   tog_q <= ~tog_q;
        end
        assign pre[i] = (sel == SRC_W'(i)) && ev[i] && tog_q;
    end

    assign src_en = |pre;
endmodule

// File: rtl/tbase_divider.sv
// Programmable enable divider; a ratio of 0 divides by 2**DIV_W.
// Assumes: adv is already qualified by the run state.
module tbase_divider
    import tbase_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [DIV_W-1:0] ratio,
    output logic             tick,
    output logic [DIV_W-1:0] div_cnt,
    output logic             half
);
    logic [DIV_W-1:0] last;
    logic [DIV_W:0]   eff;

    assign last = ratio - 1'b1;
    assign eff  = {ratio == '0, ratio};
    assign tick = adv && (div_cnt == last);
    assign half = {1'b0, div_cnt} >= (eff >> 1);

    // Count qualified enables and restart after the last one
    always_ff @(posedge clk) begin
        if (!rst_n)   div_cnt <= '0;
        else if (clr) div_cnt <= '0;
        else if (adv) div_cnt <= tick ? '0 : div_cnt + 1'b1;
    end
endmodule

// File: rtl/tbase_run_ctl.sv
// Run gating: trigger-start latch plus halt, idle and debug stops.
// Assumes: core_idle and core_debug are synchronous to clk.
module tbase_run_ctl
    import tbase_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              trig_en,
    input  logic              trig_rise,
    input  logic [TSEL_W-1:0] trig_sel,
    input  logic [N_TRIG-1:0] trig_in,
    input  logic              halt_in,
    input  logic              halt_en,
    input  logic              core_idle,
    input  logic              idle_run,
    input  logic              core_debug,
    input  logic              dbg_run,
    output logic              go,
    output logic              started,
    output logic              halt_hit
);
    logic [N_TRIG:0]   lvl;
    logic [N_TRIG-1:0] tprev_q;
    logic              t_now;
    logic              t_old;
    logic              hit_edge;

    tbase_sync #(.W(N_TRIG + 1)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({halt_in, trig_in}),
        .lvl_o  (lvl)
    );

    // Delayed copy of the trigger levels
    always_ff @(posedge clk) begin
        if (!rst_n) tprev_q <= '0;
        else        tprev_q <= lvl[N_TRIG-1:0];
    end

    assign t_now    = lvl[trig_sel];
    assign t_old    = tprev_q[trig_sel];
    assign hit_edge = trig_rise ? (t_now & ~t_old) : (~t_now & t_old);

    // Start latch: set by the chosen edge, cleared with run
    always_ff @(posedge clk) begin
        if (!rst_n)                   started <= 1'b0;
        else if (!run)                started <= 1'b0;
        else if (trig_en && hit_edge) started <= 1'b1;
    end

    assign halt_hit = halt_en && lvl[N_TRIG];
    assign go = run && (!trig_en || started) && !halt_hit
             && !(core_idle && !idle_run) && !(core_debug && !dbg_run);
endmodule

// File: rtl/tbase_counter.sv
// Time-base top: registers, limit shadow, counter and wrap flag.
// Assumes: the register write strobe lasts one cycle per access.
module tbase_counter
    import tbase_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [WD_W-1:0]   reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              tmr_ovf_in,
    input  logic              ext_in,
    input  logic              xosc_in,
    input  logic [N_TRIG-1:0] trig_in,
    input  logic              halt_in,
    input  logic              core_idle,
    input  logic              core_debug,
    output logic [CNT_W-1:0]  count_o,
    output logic              ovf_tick_o,
    output logic              ovf_flag_o,
    output logic              halt_irq_o
);
    cfg_t             cfg_q;
    logic             run_q, ovf_q, halt_q, ovf_tick_q;
    logic [CNT_W-1:0] cnt_q, lim_q, shd_q;
    logic             go, started, halt_hit, src_en, cnt_tick, wrap, half;
    logic [DIV_W-1:0] div_cnt;
    logic             wr_cfg, wr_stat, wr_count, wr_limit, wr_shadow;

    assign wr_cfg    = reg_wr && (reg_addr == A_CFG);
    assign wr_stat   = reg_wr && (reg_addr == A_STAT);
    assign wr_count  = reg_wr && (reg_addr == A_COUNT);
    assign wr_limit  = reg_wr && (reg_addr == A_LIMIT);
    assign wr_shadow = reg_wr && (reg_addr == A_SHADOW);

    tbase_clk_src u_src (
        .clk(clk), .rst_n(rst_n), .sel(cfg_q.src_sel), .clr(wr_count),
        .tmr_ovf_in(tmr_ovf_in), .ext_in(ext_in), .xosc_in(xosc_in),
        .src_en(src_en)
    );

    tbase_divider u_div (
        .clk(clk), .rst_n(rst_n), .clr(wr_count), .adv(go && src_en),
        .ratio(cfg_q.ratio), .tick(cnt_tick), .div_cnt(div_cnt), .half(half)
    );

    tbase_run_ctl u_run (
        .clk(clk), .rst_n(rst_n), .run(run_q), .trig_en(cfg_q.trig_en),
        .trig_rise(cfg_q.trig_rise), .trig_sel(cfg_q.trig_sel),
        .trig_in(trig_in), .halt_in(halt_in), .halt_en(cfg_q.halt_en),
        .core_idle(core_idle), .idle_run(cfg_q.idle_run),
        .core_debug(core_debug), .dbg_run(cfg_q.dbg_run),
        .go(go), .started(started), .halt_hit(halt_hit)
    );

    assign wrap = cnt_tick && (cnt_q == lim_q);

    // Configuration register
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (wr_cfg) cfg_q <= cfg_t'(reg_wdata);
    end

    // Run bit and the two sticky flags (set wins over clear)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            ovf_q  <= 1'b0;
            halt_q <= 1'b0;
        end else begin
            if (wr_stat) run_q <= reg_wdata[0];
            if (wrap)                         ovf_q <= 1'b1;
            else if (wr_stat && !reg_wdata[1]) ovf_q <= 1'b0;
            if (halt_hit)                     halt_q <= 1'b1;
            else if (wr_stat && !reg_wdata[2]) halt_q <= 1'b0;
        end
    end

    // Counter with wrap at the limit and the one-cycle wrap pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            ovf_tick_q <= 1'b0;
        end else begin
            ovf_tick_q <= wrap && !wr_count;
            if (wr_count)      cnt_q <= reg_wdata[CNT_W-1:0];
            else if (cnt_tick) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

    // Limit and its shadow, reloaded on wrap unless held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q <= '0;
            shd_q <= '0;
        end else begin
            if (wr_limit)                    lim_q <= reg_wdata[CNT_W-1:0];
            else if (wrap && !cfg_q.upd_hold) lim_q <= shd_q;
            if (wr_shadow) shd_q <= reg_wdata[CNT_W-1:0];
        end
    end

    // Read data multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CFG:    reg_rdata = 32'(cfg_q);
            A_STAT:   reg_rdata = {6'b0, div_cnt, 11'b0, half, started,
                                   halt_q, ovf_q, run_q};
            A_COUNT:  reg_rdata = 32'(cnt_q);
            A_LIMIT:  reg_rdata = 32'(lim_q);
            A_SHADOW: reg_rdata = 32'(shd_q);
            default:  reg_rdata = '0;
        endcase
    end

    assign count_o    = cnt_q;
    assign ovf_tick_o = ovf_tick_q;
    assign ovf_flag_o = ovf_q;
    assign halt_irq_o = halt_q && cfg_q.halt_irq_en;
endmodule

// File: rtl/tbase_chk.sv
// Property checker for the time-base counter, attached with bind.
// Assumes: the bound signals are the top's internal nets of the same names.
module tbase_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             go,
    input logic             cnt_tick,
    input logic             wrap,
    input logic             wr_count,
    input logic [CNT_W-1:0] cnt_q,
    input logic             ovf_tick_q,
    input logic             ovf_q,
    input logic             halt_q,
    input logic             halt_irq_o,
    input logic             started,
    input logic             run_q
);
    // R3: a wrap leaves the counter at zero with the pulse raised
    a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !wr_count) |=> (cnt_q == '0 && ovf_tick_q));

    // R3: a tick below the limit steps the counter by one
    a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick && !wrap && !wr_count) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R4: the wrap pulse is always accompanied by the sticky flag
    a_r4_flag_with_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_tick_q |-> ovf_q);

    // R7: the counter holds while gated off
    a_r7_frozen_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!go && !wr_count) |=> $stable(cnt_q));

    // R7: the interrupt needs the sticky halt flag
    a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        halt_irq_o |-> halt_q);

    // R6: once started, the latch holds while run stays set
    a_r6_start_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (started && run_q) |=> (started || !run_q));
endmodule

bind tbase_counter tbase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .go(go), .cnt_tick(cnt_tick), .wrap(wrap),
    .wr_count(wr_count), .cnt_q(cnt_q), .ovf_tick_q(ovf_tick_q),
    .ovf_q(ovf_q), .halt_q(halt_q), .halt_irq_o(halt_irq_o),
    .started(started), .run_q(run_q)
);

// File: tb/tbase_counter_tb_top.sv
// Scoreboard bench: drivers push expected wrap periods, a monitor checks them.
module tbase_counter_tb_top;
    import tbase_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int MAXCYC     = 200000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr = 1'b0;
    logic [2:0]      reg_addr = 3'd0;
    logic [WD_W-1:0] reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            tmr_ovf_in = 1'b0, ext_in = 1'b0, xosc_in = 1'b0;
    logic [3:0]      trig_in = 4'd0;
    logic            halt_in = 1'b0, core_idle = 1'b0, core_debug = 1'b0;
    logic [15:0]     count_o;
    logic            ovf_tick_o, ovf_flag_o, halt_irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {int per; string tag;} item_t;
    item_t exp_q[$];
    int    cyc = 0;
    int    last_wrap = 0;
    bit    have_last = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tbase_counter dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_ovf_in(tmr_ovf_in),
        .ext_in(ext_in), .xosc_in(xosc_in), .trig_in(trig_in),
        .halt_in(halt_in), .core_idle(core_idle), .core_debug(core_debug),
        .count_o(count_o), .ovf_tick_o(ovf_tick_o), .ovf_flag_o(ovf_flag_o),
        .halt_irq_o(halt_irq_o)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: on each wrap pulse, compare the interval with the next expected item
    always @(negedge clk) begin
        cyc++;
        if (rst_n && ovf_tick_o) begin
            if (have_last) begin
                if (exp_q.size() == 0) begin
                    n_chk++; n_fail++;
                    $display("FAIL R3 unexpected wrap actual=%0d expected=none", cyc - last_wrap);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    chk(it.tag, cyc - last_wrap, it.per);
                end
            end
            last_wrap = cyc;
            have_last = 1'b1;
        end
    end

    function automatic logic [WD_W-1:0] mk_cfg(input int ratio, input int src,
        input bit ten, input bit trise, input int tsel, input bit hen,
        input bit hirq, input bit irun, input bit drun, input bit hold);
        cfg_t c;
        c.ratio = DIV_W'(ratio); c.src_sel = SRC_W'(src); c.trig_en = ten;
        c.trig_rise = trise; c.trig_sel = TSEL_W'(tsel); c.halt_en = hen;
        c.halt_irq_en = hirq; c.idle_run = irun; c.dbg_run = drun; c.upd_hold = hold;
        return c;
    endfunction

    // Write one register; returns at the falling edge after the write edge
    task automatic wr(input reg_addr_e a, input longint d);
        reg_addr = a; reg_wdata = WD_W'(d); reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input reg_addr_e a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Stop the counter (flags kept) and clear count, divider and prescalers
    task automatic restart(input logic [WD_W-1:0] c);
        wr(A_STAT, 6);
        wr(A_CFG, c);
        wr(A_COUNT, 0);
        have_last = 1'b0;
    endtask

    // Run with limit/shadow, push expected periods, wait out n_wraps wraps
    task automatic period_case(input int ratio, input int lim, input int shd,
        input bit hold, input int p_first, input int p_rest, input int n_items,
        input string tag);
        int eff;
        int total;
        eff = (ratio == 0) ? 1024 : ratio;
        restart(mk_cfg(ratio, 0, 0, 0, 0, 0, 0, 0, 0, hold));
        wr(A_LIMIT, lim);
        wr(A_SHADOW, shd);
        for (int i = 0; i < n_items; i++) begin
            item_t it;
            it.per = p_rest; it.tag = tag;
            exp_q.push_back(it);
        end
        wr(A_STAT, 7);
        total = p_first + n_items * p_rest;
        wait_n(total);
        wr(A_STAT, 6);
        if (eff < 0) $display("unreachable");
    endtask

    logic [31:0] rv;
    int          c0;

    initial begin
        wait_n(4);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 count", count_o, 0);
        chk("R1 tick", ovf_tick_o, 0);
        chk("R1 flag", ovf_flag_o, 0);
        chk("R1 irq", halt_irq_o, 0);
        rd(A_STAT, rv);  chk("R1 stat", rv, 0);
        rd(A_LIMIT, rv); chk("R1 limit", rv, 0);
        rd(A_CFG, rv);   chk("R1 cfg", rv, 0);

        // R2: bus clock, ratio 1 then 3
        wr(A_LIMIT, 1000);
        restart(mk_cfg(1, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        wr(A_STAT, 7);
        chk("R2 start count", count_o, 0);
        wait_n(5);
        chk("R2 ratio1 count", count_o, 5);
        restart(mk_cfg(3, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        wr(A_STAT, 7);
        wait_n(7);
        chk("R2 ratio3 count", count_o, 2);
        // R2: divider count and half state readback, ratio 4
        restart(mk_cfg(4, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        wr(A_STAT, 7);
        wait_n(1);
        rd(A_STAT, rv); chk("R2 stat div1", rv, 32'h0001_0001);
        wait_n(1);
        rd(A_STAT, rv); chk("R2 stat div2 half", rv, 32'h0002_0011);

        // R3: wrap periods (first wrap only starts the measurement)
        period_case(1, 4, 4, 0, 5, 5, 3, "R3 period r1 l4");
        period_case(3, 2, 2, 0, 9, 9, 3, "R3 period r3 l2");
        period_case(0, 1, 1, 0, 2048, 2048, 2, "R3 period r1024 l1");

        // R4: flag survives a write of 1, clears on a write of 0
        chk("R4 flag set", ovf_flag_o, 1);
        wr(A_STAT, 6);
        chk("R4 flag kept", ovf_flag_o, 1);
        wr(A_STAT, 4);
        chk("R4 flag cleared", ovf_flag_o, 0);

        // R5: shadow reload versus update hold
        period_case(1, 3, 6, 0, 4, 7, 2, "R5 period reload");
        rd(A_LIMIT, rv); chk("R5 limit reloaded", rv, 6);
        period_case(1, 3, 6, 1, 4, 4, 3, "R5 period held");
        rd(A_LIMIT, rv); chk("R5 limit held", rv, 3);
        chk("R3 queue drained", exp_q.size(), 0);

        // R6: trigger start on rising edge of trig_in[2]
        restart(mk_cfg(1, 0, 1, 1, 2, 0, 0, 0, 0, 0));
        wr(A_LIMIT, 1000);
        wr(A_STAT, 7);
        wait_n(5);
        chk("R6 armed no count", count_o, 0);
        trig_in[1] = 1'b1; wait_n(4); trig_in[1] = 1'b0; wait_n(4);
        chk("R6 wrong trigger", count_o, 0);
        rd(A_STAT, rv); chk("R6 not started", rv[3], 0);
        trig_in[2] = 1'b1; wait_n(6);
        chk("R6 rising start", count_o, 3);
        rd(A_STAT, rv); chk("R6 started bit", rv[3], 1);
        trig_in[2] = 1'b0; wait_n(4);
        chk("R6 keeps running", count_o, 7);
        // R6: falling-edge qualifier ignores the rising edge
        restart(mk_cfg(1, 0, 1, 0, 2, 0, 0, 0, 0, 0));
        wr(A_STAT, 7);
        trig_in[2] = 1'b1; wait_n(6);
        chk("R6 rising ignored", count_o, 0);
        trig_in[2] = 1'b0; wait_n(6);
        chk("R6 falling start", count_o, 3);

        // R7: halt input freezes and flags
        restart(mk_cfg(1, 0, 0, 0, 0, 1, 1, 0, 0, 0));
        wr(A_STAT, 7);
        wait_n(4);
        chk("R7 pre-halt count", count_o, 4);
        halt_in = 1'b1; wait_n(6);
        chk("R7 frozen", count_o, 6);
        chk("R7 irq", halt_irq_o, 1);
        halt_in = 1'b0; wait_n(4);
        chk("R7 resumed", count_o, 8);
        wr(A_STAT, 3);
        chk("R7 irq cleared", halt_irq_o, 0);
        wr(A_CFG, mk_cfg(1, 0, 0, 0, 0, 0, 1, 0, 0, 0));
        c0 = count_o;
        halt_in = 1'b1; wait_n(5);
        chk("R7 halt ignored count", count_o, c0 + 5);
        rd(A_STAT, rv); chk("R7 halt ignored flag", rv[2], 0);
        halt_in = 1'b0;

        // R8: idle and debug stops with their bypass bits
        core_idle = 1'b1;
        c0 = count_o; wait_n(5);
        chk("R8 idle freeze", count_o, c0);
        wr(A_CFG, mk_cfg(1, 0, 0, 0, 0, 0, 0, 1, 0, 0));
        c0 = count_o; wait_n(3);
        chk("R8 idle bypass", count_o, c0 + 3);
        core_idle = 1'b0;
        core_debug = 1'b1;
        wr(A_CFG, mk_cfg(1, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        c0 = count_o; wait_n(5);
        chk("R8 debug freeze", count_o, c0);
        wr(A_CFG, mk_cfg(1, 0, 0, 0, 0, 0, 0, 0, 1, 0));
        c0 = count_o; wait_n(3);
        chk("R8 debug run", count_o, c0 + 3);
        core_debug = 1'b0;

        // R9: source 1, four timer events -> two counts
        restart(mk_cfg(1, 1, 0, 0, 0, 0, 0, 0, 0, 0));
        wr(A_STAT, 7);
        wait_n(4);
        chk("R9 src1 idle", count_o, 0);
        for (int i = 0; i < 4; i++) begin
            tmr_ovf_in = 1'b1; wait_n(1); tmr_ovf_in = 1'b0; wait_n(2);
        end
        wait_n(2);
        chk("R9 src1 count", count_o, 2);
        // R9: source 2, four ext_in periods -> four falls -> two counts
        restart(mk_cfg(1, 2, 0, 0, 0, 0, 0, 0, 0, 0));
        wr(A_STAT, 7);
        for (int i = 0; i < 4; i++) begin
            ext_in = 1'b1; wait_n(4); ext_in = 1'b0; wait_n(4);
        end
        chk("R9 src2 falls", count_o, 2);
        // R9: source 3, four oscillator rises -> two counts
        restart(mk_cfg(1, 3, 0, 0, 0, 0, 0, 0, 0, 0));
        wr(A_STAT, 7);
        for (int i = 0; i < 4; i++) begin
            xosc_in = 1'b1; wait_n(4); xosc_in = 1'b0; wait_n(4);
        end
        chk("R9 src3 rises", count_o, 2);
        // R9: source 4, same ext_in waveform -> eight transitions -> four counts
        restart(mk_cfg(1, 4, 0, 0, 0, 0, 0, 0, 0, 0));
        wr(A_STAT, 7);
        for (int i = 0; i < 4; i++) begin
            ext_in = 1'b1; wait_n(4); ext_in = 1'b0; wait_n(4);
        end
        chk("R9 src4 transitions", count_o, 4);

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (MAXCYC) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule